// File: doc/BRIEF.md
# Clock Generator and PLL-Lock Controller

This unit manages clocks and power for a small microcontroller. A register bus programs a clock generator mode word covering the PLL multiplier, the lock wait in slow-clock periods, the master clock source, the source and divide ratio of a clock-output pin, a pin disable and a PLL range select. Separate set and clear registers turn the clocks of thirteen peripherals on and off (USART 0 to 2 on bits 0 to 2, SPI A and B on bits 3 and 4, timer/counters 0 to 5 on bits 5 to 10, parallel I/O A and B on bits 11 and 12). A CPU stop request parks the processor in idle until an interrupt arrives.

Analog parts are modelled. The 32,768 Hz slow clock and the PLL output are levels sampled in the `clk` domain, and each rising edge of the slow clock is one lock-count tick. The oscillator-stable input is a level. The PLL lock state machine has three states. PLL_OFF is entered on any write that sets the multiplier to zero. A write that changes the multiplier to a non-zero value restarts the count from zero in PLL_COUNT, from any state. PLL_COUNT moves to PLL_LOCKED on the first cycle in which the count has reached the programmed lock value. The CPU state machine moves from CPU_RUN to CPU_IDLE when 1 is written to bit 0 of the stop register. It moves from CPU_IDLE back to CPU_RUN when the interrupt line is high.

Register word addresses: 0 CPU stop (W), 1 CPU status (R, bit 0 = CPU clock running), 2 peripheral set (W1S), 3 peripheral clear (W1C), 4 peripheral status (R), 5 mode word (R/W), 6 flag status (R, read clears pending), 7 mask set, 8 mask clear, 9 mask (R). Mode word layout: multiplier [5:0], lock count [13:6], master source [14], output source [16:15], prescaler [19:17], pin disable [20], PLL range [21]; bits 31:22 read as zero.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset all peripheral enables, the mode word, the mask and the pending flags are zero, the CPU clock runs, `irq_o` is 0 and `clko_oe_o` is 1.
- R2: Writing address 2 sets and writing address 3 clears exactly the peripheral enable bits written as 1. Bits 31:13 of the write are ignored. Address 4 and `per_clk_en_o` show the resulting enables.
- R3: `pll_en_o` is 1 exactly when the multiplier is non-zero. A multiplier of zero keeps the lock flag at 0 whatever slow-clock ticks arrive.
- R4: After a multiplier change to a non-zero value with lock count N, the lock flag (status bit 1) rises in the cycle after the N-th slow-clock rising edge, and not before.
- R5: A mode write that changes the multiplier clears the lock flag and restarts the count from zero. A mode write with an unchanged multiplier leaves the lock untouched.
- R6: `mck_o` follows `pll_clk_i` only when the source bit (mode bit 14) is 1 and the PLL is locked. Otherwise it follows `slow_clk_i`.
- R7: The output source field picks 0 = slow clock, 1 = master clock, 2 = inverted master clock, 3 = master clock halved, toggling on each master rising edge. The pin reflects the choice one cycle later.
- R8: A prescaler value P divides the selected output source by 2 to the power P. P = 0 passes it through.
- R9: Mode bit 20 set drives `clko_oe_o` to 0 (pin tri-stated). Cleared, `clko_oe_o` is 1.
- R10: Writing 1 to bit 0 of address 0 drops `cpu_clk_en_o` and status bit 0 of address 1. Writing 0 there has no effect. The CPU clock returns once `irq_o` is high.
- R11: Status bit 0 is the oscillator-stable flag and bit 1 the lock flag. A rising flag sets a pending bit. `irq_o` is the OR of pending bits that are unmasked. A read of address 6 clears the pending bits.
- R12: Mask bits are set by writing 1s to address 7 and cleared by writing 1s to address 8. They read back at address 9. A masked pending flag does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| slow_clk_i | input | 1 | Sampled 32,768 Hz slow clock level |
| pll_clk_i | input | 1 | Sampled PLL output level |
| osc_stable_i | input | 1 | Main oscillator stable level |
| pll_en_o | output | 1 | PLL run request |
| pll_range_o | output | 1 | PLL frequency range select |
| mck_o | output | 1 | Master clock level |
| clko_o | output | 1 | Clock-output pin data |
| clko_oe_o | output | 1 | Clock-output pin drive enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 13 | Peripheral clock enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts slow-clock pulses around the lock boundary. A counter that is off by one would report lock one tick early or late. It rewrites the mode word with both the same and a different multiplier. A design that restarted on every mode write would lose lock, and one that never restarted would keep a stale lock. It selects the PLL source before lock and checks that the master clock stays on the slow clock, which catches a mux that ignores lock. It also counts output-pin edges under each divide and source setting, and confirms that a stop write of 0 leaves the CPU idle.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int NUM_PER = 13;
    localparam int MULT_W  = 6;
    localparam int LOCK_W  = 8;
    localparam int PRES_W  = 3;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int NUM_FLG = 2;
    localparam int FLG_OSC  = 0;
    localparam int FLG_LOCK = 1;
    localparam int DIV_W   = (1 << PRES_W) - 1;

    typedef enum logic [1:0] {
        OSEL_SLOW     = 2'd0,
        OSEL_MCK      = 2'd1,
        OSEL_MCK_INV  = 2'd2,
        OSEL_MCK_HALF = 2'd3
    } osel_e;

    typedef struct packed {
        logic              range_hi;
        logic              out_off;
        logic [PRES_W-1:0] pres;
        osel_e             osel;
        logic              css;
        logic [LOCK_W-1:0] lock_cnt;
        logic [MULT_W-1:0] mult;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        PLL_OFF    = 2'd0,
        PLL_COUNT  = 2'd1,
        PLL_LOCKED = 2'd2
    } pll_state_e;

    typedef enum logic {
        CPU_RUN  = 1'b0,
        CPU_IDLE = 1'b1
    } cpu_state_e;

    localparam logic [ADDR_W-1:0] A_SYS_OFF  = 4'h0;
    localparam logic [ADDR_W-1:0] A_SYS_STAT = 4'h1;
    localparam logic [ADDR_W-1:0] A_PER_SET  = 4'h2;
    localparam logic [ADDR_W-1:0] A_PER_CLR  = 4'h3;
    localparam logic [ADDR_W-1:0] A_PER_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] A_MODE     = 4'h5;
    localparam logic [ADDR_W-1:0] A_STATUS   = 4'h6;
    localparam logic [ADDR_W-1:0] A_MSK_SET  = 4'h7;
    localparam logic [ADDR_W-1:0] A_MSK_CLR  = 4'h8;
    localparam logic [ADDR_W-1:0] A_MASK     = 4'h9;

endpackage

// File: rtl/clkpm_lock.sv
module clkpm_lock
    import clkpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [MULT_W-1:0] mult_next,
    input  logic [MULT_W-1:0] mult_cur,
    input  logic [LOCK_W-1:0] target,
    output logic              locked
);

    pll_state_e        state, state_nx;
    logic [LOCK_W-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PLL_OFF;
            cnt   <= '0;
        end else if (restart) begin
            state <= (mult_next == '0) ? PLL_OFF : PLL_COUNT;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PLL_OFF: begin
                cnt_nx = '0;
            end
            PLL_COUNT: begin
                if (cnt >= target)
                    state_nx = PLL_LOCKED;
                else if (tick)
                    cnt_nx = cnt + LOCK_W'(1);
            end
            PLL_LOCKED: begin
                state_nx = PLL_LOCKED;
            end
            default: state_nx = PLL_OFF;
        endcase
    end

    // outputs
    always_comb begin
        locked = (state == PLL_LOCKED);
    end

    AST_LOCK_NEEDS_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (mult_cur != '0));   // R3
    AST_LOCK_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(cnt) >= $past(target)));   // R4
    AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PLL_COUNT && !restart) |=> (cnt >= $past(cnt)));   // R4
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!locked && cnt == '0));   // R5

endmodule

// File: rtl/clkpm_clkout.sv
module clkpm_clkout
    import clkpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  slow_clk,
    input  logic  pll_clk,
    input  logic  pll_locked,
    input  mode_t mode,
    output logic  slow_tick,
    output logic  mck,
    output logic  clko,
    output logic  clko_oe
);

    logic             slow_q, mck_q, half, src_q, clko_q;
    logic             src, src_rise, mck_rise, pin_d;
    logic [DIV_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q <= 1'b0;
            mck_q  <= 1'b0;
            half   <= 1'b0;
            src_q  <= 1'b0;
            pcnt   <= '0;
            clko_q <= 1'b0;
        end else begin
            slow_q <= slow_clk;
            mck_q  <= mck;
            src_q  <= src;
            clko_q <= pin_d;
            if (mck_rise) half <= ~half;
            if (src_rise) pcnt <= pcnt + DIV_W'(1);
        end
    end

    always_comb begin
        slow_tick = slow_clk & ~slow_q;
        mck       = (mode.css && pll_locked) ? pll_clk : slow_clk;
        mck_rise  = mck & ~mck_q;
        unique case (mode.osel)
            OSEL_SLOW:     src = slow_clk;
            OSEL_MCK:      src = mck;
            OSEL_MCK_INV:  src = ~mck;
            OSEL_MCK_HALF: src = half;
            default:       src = slow_clk;
        endcase
        src_rise = src & ~src_q;
        if (mode.pres == '0)
            pin_d = src;
        else
            pin_d = pcnt[mode.pres - PRES_W'(1)];
        clko    = clko_q;
        clko_oe = ~mode.out_off;
    end

    AST_MCK_SLOW_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |-> (mck == slow_clk));   // R6
    AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mck_rise |=> (half != $past(half)));   // R7
    AST_PIN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.pres == '0 && mode.osel == OSEL_SLOW && $stable(mode)) |=> (clko == $past(slow_clk)));   // R7

endmodule

// File: rtl/clkpm_regs.sv
module clkpm_regs
    import clkpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               pll_locked,
    input  logic               osc_stable,
    output mode_t              mode,
    output logic               restart,
    output logic [MULT_W-1:0]  mult_next,
    output logic [NUM_PER-1:0] per_en,
    output logic               cpu_run,
    output logic               irq
);

    logic               wr, rd;
    logic               wr_sysoff, wr_pset, wr_pclr, wr_mode, wr_mset, wr_mclr, rd_stat;
    mode_t              mode_wr;
    logic [NUM_FLG-1:0] mask, pend, flags, flags_prev, rise;
    logic               osc_q;
    cpu_state_e         cpu_st, cpu_nx;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:MODE_W];

    always_comb begin
        wr        = bus_sel & bus_we;
        rd        = bus_sel & ~bus_we;
        wr_sysoff = wr && (bus_addr == A_SYS_OFF);
        wr_pset   = wr && (bus_addr == A_PER_SET);
        wr_pclr   = wr && (bus_addr == A_PER_CLR);
        wr_mode   = wr && (bus_addr == A_MODE);
        wr_mset   = wr && (bus_addr == A_MSK_SET);
        wr_mclr   = wr && (bus_addr == A_MSK_CLR);
        rd_stat   = rd && (bus_addr == A_STATUS);
        mode_wr   = mode_t'(bus_wdata[MODE_W-1:0]);
        mult_next = mode_wr.mult;
        restart   = wr_mode && (mode_wr.mult != mode.mult);
    end

    // configuration and enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= '0;
            per_en <= '0;
            mask   <= '0;
        end else begin
            if (wr_mode) mode <= mode_wr;
            if (wr_pset)
                per_en <= per_en | bus_wdata[NUM_PER-1:0];
            else if (wr_pclr)
                per_en <= per_en & ~bus_wdata[NUM_PER-1:0];
            if (wr_mset)
                mask <= mask | bus_wdata[NUM_FLG-1:0];
            else if (wr_mclr)
                mask <= mask & ~bus_wdata[NUM_FLG-1:0];
        end
    end

    // status flags and pending bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q      <= 1'b0;
            flags_prev <= '0;
            pend       <= '0;
        end else begin
            osc_q      <= osc_stable;
            flags_prev <= flags;
            pend       <= rise | (rd_stat ? '0 : pend);
        end
    end

    always_comb begin
        flags           = '0;
        flags[FLG_OSC]  = osc_q;
        flags[FLG_LOCK] = pll_locked;
        rise            = flags & ~flags_prev;
        irq             = |(pend & mask);
    end

    // CPU state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cpu_st <= CPU_RUN;
        else        cpu_st <= cpu_nx;
    end

    // CPU next state
    always_comb begin
        cpu_nx = cpu_st;
        unique case (cpu_st)
            CPU_RUN:  if (wr_sysoff && bus_wdata[0]) cpu_nx = CPU_IDLE;
            CPU_IDLE: if (irq) cpu_nx = CPU_RUN;
            default:  cpu_nx = CPU_RUN;
        endcase
    end

    // outputs and read mux
    always_comb begin
        cpu_run   = (cpu_st == CPU_RUN);
        bus_rdata = '0;
        unique case (bus_addr)
            A_SYS_STAT: bus_rdata = DATA_W'(cpu_run);
            A_PER_STAT: bus_rdata = DATA_W'(per_en);
            A_MODE:     bus_rdata = DATA_W'(mode);
            A_STATUS:   bus_rdata = DATA_W'(flags);
            A_MASK:     bus_rdata = DATA_W'(mask);
            default:    bus_rdata = '0;
        endcase
    end

    AST_PER_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pset |=> ((per_en & $past(bus_wdata[NUM_PER-1:0])) == $past(bus_wdata[NUM_PER-1:0])));   // R2
    AST_PER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pclr |=> ((per_en & $past(bus_wdata[NUM_PER-1:0])) == '0));   // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && rise == '0) |=> (pend == '0));   // R11
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask & $past(bus_wdata[NUM_FLG-1:0])) == '0));   // R12
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sysoff && bus_wdata[0]) |=> !cpu_run);   // R10

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               slow_clk_i,
    input  logic               pll_clk_i,
    input  logic               osc_stable_i,
    output logic               pll_en_o,
    output logic               pll_range_o,
    output logic               mck_o,
    output logic               clko_o,
    output logic               clko_oe_o,
    output logic               cpu_clk_en_o,
    output logic [NUM_PER-1:0] per_clk_en_o,
    output logic               irq_o
);

    mode_t             mode;
    logic              restart, locked, tick, cpu_run;
    logic [MULT_W-1:0] mult_next;

    clkpm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_locked (locked),
        .osc_stable (osc_stable_i),
        .mode       (mode),
        .restart    (restart),
        .mult_next  (mult_next),
        .per_en     (per_clk_en_o),
        .cpu_run    (cpu_run),
        .irq        (irq_o)
    );

    clkpm_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .restart   (restart),
        .mult_next (mult_next),
        .mult_cur  (mode.mult),
        .target    (mode.lock_cnt),
        .locked    (locked)
    );

    clkpm_clkout u_clkout (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_clk   (slow_clk_i),
        .pll_clk    (pll_clk_i),
        .pll_locked (locked),
        .mode       (mode),
        .slow_tick  (tick),
        .mck        (mck_o),
        .clko       (clko_o),
        .clko_oe    (clko_oe_o)
    );

    always_comb begin
        pll_en_o     = (mode.mult != '0);
        pll_range_o  = mode.range_hi;
        cpu_clk_en_o = cpu_run;
    end

    AST_PLL_EN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && mult_next != '0) |=> pll_en_o);   // R3

endmodule

// File: tb/test_clkpm_ctrl.sv
module test_clkpm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_clk_i = 1'b0, pll_clk_i = 1'b0, osc_stable_i = 1'b0;
    logic        pll_en_o, pll_range_o, mck_o, clko_o, clko_oe_o, cpu_clk_en_o, irq_o;
    logic [12:0] per_clk_en_o;

    int n_chk = 0, n_fail = 0, rises = 0;
    logic prev_clko = 1'b0;
    logic done = 1'b0;

    typedef struct packed {
        logic        we;
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h2, 32'h0000_1055, 32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0000_1055},
        '{1'b1, 4'h3, 32'h0000_0005, 32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0000_1050},
        '{1'b1, 4'h2, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0000_1FFF},
        '{1'b1, 4'h3, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 4'h4, 32'h0,         32'h0},
        '{1'b1, 4'h7, 32'h0000_0003, 32'h0},
        '{1'b0, 4'h9, 32'h0,         32'h3},
        '{1'b1, 4'h8, 32'h0000_0001, 32'h0},
        '{1'b0, 4'h9, 32'h0,         32'h2},
        '{1'b1, 4'h8, 32'h0000_0002, 32'h0},
        '{1'b0, 4'h9, 32'h0,         32'h0},
        '{1'b1, 4'h5, 32'h003F_FFC0, 32'h0},
        '{1'b0, 4'h5, 32'h0,         32'h003F_FFC0},
        '{1'b1, 4'h5, 32'hFFC0_0000, 32'h0},
        '{1'b0, 4'h5, 32'h0,         32'h0},
        '{1'b0, 4'h1, 32'h0,         32'h1}
    };

    clkpm_ctrl i_clkpm_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .slow_clk_i   (slow_clk_i),
        .pll_clk_i    (pll_clk_i),
        .osc_stable_i (osc_stable_i),
        .pll_en_o     (pll_en_o),
        .pll_range_o  (pll_range_o),
        .mck_o        (mck_o),
        .clko_o       (clko_o),
        .clko_oe_o    (clko_oe_o),
        .cpu_clk_en_o (cpu_clk_en_o),
        .per_clk_en_o (per_clk_en_o),
        .irq_o        (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (clko_o && !prev_clko) rises++;
        prev_clko = clko_o;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        step();
        bus_sel = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            slow_clk_i = 1'b1; step();
            slow_clk_i = 1'b0; step();
        end
    endtask

    task automatic count_rises(input logic [31:0] mode_w, input int exp, input string req);
        slow_clk_i = 1'b0;
        wr(4'h5, mode_w);
        repeat (3) step();
        rises = 0;
        pulses(4);
        repeat (3) step();
        chk(req, rises, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 oe", clko_oe_o, 1);
        chk("R1 pll_en", pll_en_o, 0);
        chk("R1 cpu", cpu_clk_en_o, 1);
        chk("R1 per", per_clk_en_o, 0);
        rd(4'h5, 0, "R1 mode");
        rd(4'h9, 0, "R1 mask");
        rd(4'h6, 0, "R1 status");

        // table: R2 enables, R12 masks, mode readback, CPU status
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].a, VEC[i].d);
            else rd(VEC[i].a, VEC[i].e, "R2/R12 table");
        end

        // R2 at the ports
        wr(4'h2, 32'h0101);
        chk("R2 per port set", per_clk_en_o, 13'h0101);
        wr(4'h3, 32'h0001);
        chk("R2 per port clr", per_clk_en_o, 13'h0100);

        // R3/R4 lock counting: mult 5, lock count 3
        wr(4'h5, 32'h0000_00C5);
        chk("R3 pll_en", pll_en_o, 1);
        rd(4'h6, 0, "R4 not locked at start");
        pulses(2);
        rd(4'h6, 0, "R4 not locked after 2 ticks");
        pulses(1);
        rd(4'h6, 2, "R4 locked after 3 ticks");
        chk("R12 masked lock no irq", irq_o, 0);
        wr(4'h7, 32'h2);
        chk("R11 irq on unmasked lock", irq_o, 1);
        rd(4'h6, 2, "R11 status read");
        chk("R11 irq cleared by read", irq_o, 0);

        // R5 same multiplier keeps lock; R6 PLL source when locked
        wr(4'h5, 32'h0000_40C5);
        rd(4'h6, 2, "R5 same mult keeps lock");
        pll_clk_i = 1'b1; slow_clk_i = 1'b0; #1;
        chk("R6 mck from pll", mck_o, 1);
        pll_clk_i = 1'b0; #1;
        chk("R6 mck from pll low", mck_o, 0);

        // R5 changed multiplier restarts; R6 slow while unlocked
        wr(4'h5, 32'h0000_40C6);
        rd(4'h6, 0, "R5 mult change clears lock");
        pll_clk_i = 1'b1; #1;
        chk("R6 mck slow while unlocked", mck_o, 0);
        pll_clk_i = 1'b0;
        pulses(2);
        rd(4'h6, 0, "R5 restarted count");
        pulses(1);
        rd(4'h6, 2, "R4 relock");

        // R3 multiplier zero
        wr(4'h5, 32'h0000_40C0);
        chk("R3 pll off", pll_en_o, 0);
        rd(4'h6, 0, "R3 lock dropped");
        pulses(4);
        rd(4'h6, 0, "R3 no lock with mult 0");
        wr(4'h8, 32'h3);

        // R7 output source selection
        wr(4'h5, 32'h0);
        slow_clk_i = 1'b1; step();
        chk("R7 slow source", clko_o, 1);
        wr(4'h5, 32'h0001_0000);
        step();
        chk("R7 inverted mck", clko_o, 0);
        wr(4'h5, 32'h0000_8000);
        step();
        chk("R7 mck source", clko_o, 1);
        count_rises(32'h0001_8000, 2, "R7 mck half");

        // R8 prescaler
        count_rises(32'h0000_8000, 4, "R8 pres 0");
        count_rises(32'h0002_8000, 2, "R8 pres 1");
        count_rises(32'h0004_8000, 1, "R8 pres 2");

        // R9 pin disable
        wr(4'h5, 32'h0010_0000);
        chk("R9 tri-state", clko_oe_o, 0);
        wr(4'h5, 32'h0);
        chk("R9 driven", clko_oe_o, 1);

        // R10 idle and wake
        rd(4'h6, 0, "R11 clear before idle");
        wr(4'h0, 32'h1);
        chk("R10 cpu stopped", cpu_clk_en_o, 0);
        rd(4'h1, 0, "R10 cpu status");
        wr(4'h0, 32'h0);
        chk("R10 write 0 no effect", cpu_clk_en_o, 0);
        wr(4'h7, 32'h1);
        osc_stable_i = 1'b1;
        repeat (4) step();
        chk("R11 osc irq", irq_o, 1);
        chk("R10 wake on irq", cpu_clk_en_o, 1);
        rd(4'h6, 1, "R11 osc flag");
        chk("R11 irq cleared", irq_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule